// File: doc/BRIEF.md
# Dual countdown timer with level interrupt

This block holds two countdown channels of the kind found next to the tone generators of a sound chip. Each channel counts down from an 8-bit divisor. A channel is clocked either by a shared base tick or directly by the master clock. The base tick comes from one of two free-running prescalers: one divides the master clock by 28, the other divides it by 114, which is one video line. When a channel passes zero, it reloads from its divisor and can raise a level-sensitive interrupt request. That request stays high until software drops the channel's enable bit. The two channels can also be joined into one 16-bit counter. Each channel also drives a 4-bit volume-only audio level.

Software writes to eight byte-wide locations on a simple write bus. The start strobe reloads the counters but leaves the prescalers running. Only the init state holds the prescalers at zero. As a result, the position of a slow-clocked interrupt within a video line is set by the cycle at which software leaves the init state.

Top module: `audio_timer`

## Requirements
- R1: After reset the interrupt output is low, both audio levels are 0, and the init state is active, so the prescalers are held.
- R2: Mode register (address 4) bit 0 picks the base tick for all slow-clocked channels: 0 selects the master divided by 28, 1 selects the master divided by 114. A channel with divisor D then underflows every (D+1) base ticks.
- R3: Mode bit 1 (channel 0) or bit 2 (channel 1) clocks that channel at the master rate. The underflow then comes D+1 cycles after a start strobe and repeats every D+1 cycles.
- R4: Any write to address 5 (start) loads both counters from their divisors. It does not reset the prescalers, so the first slow underflow follows the prescaler phase and not the strobe.
- R5: Writing a value whose low two bits are 00 to address 6 enters the init state. In this state both prescalers are held at zero and give no ticks. A value whose low bits are 11 leaves it, and the first /28 tick then comes on the 28th clock after the leaving write.
- R6: An underflow sets a channel's interrupt status only if that channel's enable bit is 1 at that moment. Enable bit 0 (address 7) belongs to channel 0 and bit 1 to channel 1. The output `irq` is the OR of the status bits.
- R7: Set status holds `irq` high until a write to address 7 clears that channel's enable bit. The status is cleared on the clock of that write.
- R8: Mode bit 3 joins the channels into one 16-bit counter. Channel 0's divisor is the low byte, and the counter is clocked by channel 0's clock choice. Underflow sets only channel 1's status.
- R9: Channel control registers are at address 1 (channel 0) and address 3 (channel 1). When bit 4 is set, the audio level of that channel equals bits 3:0. When bit 4 is clear, the level is 0. Channel 0 drives `aud[3:0]` and channel 1 drives `aud[7:4]`.
- R10: On underflow a counter reloads from its divisor, so the channel keeps a steady period without a new start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | register address (0 div0, 1 ctl0, 2 div1, 3 ctl1, 4 mode, 5 start, 6 init, 7 enable) |
| wr_data | input | 8 | write data |
| irq | output | 1 | level interrupt request |
| aud | output | 8 | volume levels, channel 0 in bits 3:0 |

## Verification
The case that is hardest to reach from the ports is a slow-clocked underflow whose timing comes from the prescaler phase and not from the start strobe. To reach it, the stimulus keeps the block in the init state and then releases it on a known cycle. It issues a start strobe ten cycles later with a zero divisor, and measures the distance from the release to the interrupt. A second case is the joined counter: it is given a period long enough that a separate low channel would have interrupted many times first. A behavioural model follows every write and is compared on every cycle.

// File: rtl/audtmr_pkg.sv
package audtmr_pkg;
  typedef enum logic [2:0] {
    RA_DIV0  = 3'd0,
    RA_CTL0  = 3'd1,
    RA_DIV1  = 3'd2,
    RA_CTL1  = 3'd3,
    RA_MODE  = 3'd4,
    RA_START = 3'd5,
    RA_INIT  = 3'd6,
    RA_IRQEN = 3'd7
  } reg_addr_e;

  localparam int MB_LINE  = 0;
  localparam int MB_FAST0 = 1;
  localparam int MB_PAIR  = 3;
  localparam int CB_VOLONLY = 4;
endpackage

// File: rtl/audtmr_prescale.sv
module audtmr_prescale #(
  parameter int DIV = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = !hold && (cnt_q == LAST);

  always_comb begin
    if (hold || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/audtmr_count.sv
module audtmr_count #(
  parameter int DW  = 8,
  parameter int NCH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    pair,
  input  logic [NCH-1:0]          tick,
  input  logic [NCH-1:0][DW-1:0]  div,
  output logic [NCH-1:0]          uf
);
  logic [NCH-1:0][DW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    uf    = '0;
    if (start) begin
      cnt_d = div;
    end else if (pair) begin
      if (tick[0]) begin
        if (cnt_q == '0) begin
          uf[1] = 1'b1;
          cnt_d = div;
        end else begin
          cnt_d = cnt_q - (NCH*DW)'(1);
        end
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (tick[i]) begin
          if (cnt_q[i] == '0) begin
            uf[i]    = 1'b1;
            cnt_d[i] = div[i];
          end else begin
            cnt_d[i] = cnt_q[i] - DW'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/audtmr_irq.sv
module audtmr_irq #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] uf,
  input  logic           en_wr,
  input  logic [NCH-1:0] en_data,
  output logic [NCH-1:0] en_q,
  output logic [NCH-1:0] status_q,
  output logic           irq
);
  logic [NCH-1:0] en_d, status_d, keep;

  always_comb begin
    keep     = en_wr ? en_data : '1;
    en_d     = en_wr ? en_data : en_q;
    status_d = (status_q | (uf & en_q)) & keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      status_q <= '0;
    end else begin
      en_q     <= en_d;
      status_q <= status_d;
    end
  end

  assign irq = |status_q;
endmodule

// File: rtl/audio_timer.sv
module audio_timer #(
  parameter int DW       = 8,
  parameter int MID_DIV  = 28,
  parameter int LINE_DIV = 114
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       irq,
  output logic [7:0] aud
);
  import audtmr_pkg::*;

  localparam int NCH = 2;
  localparam int VW  = 4;

  logic [NCH-1:0][DW-1:0] div_q, div_d;
  logic [NCH-1:0][7:0]    ctl_q, ctl_d;
  logic [7:0]             mode_q, mode_d;
  logic                   init_q, init_d;
  logic                   start, en_wr;
  logic                   tick_mid, tick_line, base_tick;
  logic [NCH-1:0]         tick, uf, en_q, status_q;

  always_comb begin
    div_d  = div_q;
    ctl_d  = ctl_q;
    mode_d = mode_q;
    init_d = init_q;
    if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        RA_DIV0: div_d[0] = wr_data[DW-1:0];
        RA_CTL0: ctl_d[0] = wr_data;
        RA_DIV1: div_d[1] = wr_data[DW-1:0];
        RA_CTL1: ctl_d[1] = wr_data;
        RA_MODE: mode_d   = wr_data;
        RA_INIT: begin
          if (wr_data[1:0] == 2'b00)      init_d = 1'b1;
          else if (wr_data[1:0] == 2'b11) init_d = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ctl_q  <= '0;
      mode_q <= '0;
      init_q <= 1'b1;
    end else begin
      div_q  <= div_d;
      ctl_q  <= ctl_d;
      mode_q <= mode_d;
      init_q <= init_d;
    end
  end

  assign start = wr_en && (wr_addr == RA_START);
  assign en_wr = wr_en && (wr_addr == RA_IRQEN);

  audtmr_prescale #(.DIV(MID_DIV)) u_pre_mid (
    .clk(clk), .rst_n(rst_n), .hold(init_q), .tick(tick_mid)
  );
  audtmr_prescale #(.DIV(LINE_DIV)) u_pre_line (
    .clk(clk), .rst_n(rst_n), .hold(init_q), .tick(tick_line)
  );

  assign base_tick = mode_q[MB_LINE] ? tick_line : tick_mid;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign tick[g] = mode_q[MB_FAST0 + g] | base_tick;
    assign aud[g*VW +: VW] = ctl_q[g][CB_VOLONLY] ? ctl_q[g][VW-1:0] : '0;
  end

  audtmr_count #(.DW(DW), .NCH(NCH)) u_count (
    .clk(clk), .rst_n(rst_n), .start(start), .pair(mode_q[MB_PAIR]),
    .tick(tick), .div(div_q), .uf(uf)
  );

  audtmr_irq #(.NCH(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n), .uf(uf), .en_wr(en_wr),
    .en_data(wr_data[NCH-1:0]), .en_q(en_q), .status_q(status_q), .irq(irq)
  );
endmodule

// File: rtl/audio_timer_chk.sv
module audio_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       irq,
  input logic [7:0] aud,
  input logic       init_q,
  input logic       tick_mid,
  input logic       tick_line,
  input logic [1:0] en_q
);
  // R5
  init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |-> (!tick_mid && !tick_line));

  // R6
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(en_q) != 2'b00));

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && wr_addr == 3'd7)) |=> irq);

  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd7 && wr_data[1:0] == 2'b00) |=> !irq);

  // R9
  vol_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd1 && wr_data[4]) |=> (aud[3:0] == $past(wr_data[3:0])));
endmodule

bind audio_timer audio_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .irq(irq), .aud(aud), .init_q(init_q), .tick_mid(tick_mid),
  .tick_line(tick_line), .en_q(en_q)
);

// File: tb/audio_timer_test.sv
module audio_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       irq;
  logic [7:0] aud;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  audio_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq(irq), .aud(aud)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural reference
  int m_p28, m_p114, m_c0, m_c1, m_d0, m_d1, m_k0, m_k1, m_md, m_ini, m_en, m_st;
  always @(posedge clk or negedge rst_n) begin
    int t28, t114, b, tk0, tk1, u0, u1, v, nv;
    if (!rst_n) begin
      m_p28 = 0; m_p114 = 0; m_c0 = 0; m_c1 = 0; m_d0 = 0; m_d1 = 0;
      m_k0 = 0; m_k1 = 0; m_md = 0; m_ini = 1; m_en = 0; m_st = 0;
    end else begin
      t28  = (m_ini == 0 && m_p28 == 27) ? 1 : 0;
      t114 = (m_ini == 0 && m_p114 == 113) ? 1 : 0;
      b    = (m_md & 1) ? t114 : t28;
      tk0  = (m_md & 2) ? 1 : b;
      tk1  = (m_md & 4) ? 1 : b;
      u0 = 0; u1 = 0;
      if (wr_en && wr_addr == 3'd5) begin
        m_c0 = m_d0; m_c1 = m_d1;
      end else if (m_md & 8) begin
        if (tk0 != 0) begin
          v = m_c1 * 256 + m_c0;
          if (v == 0) begin u1 = 1; nv = m_d1 * 256 + m_d0; end
          else nv = v - 1;
          m_c0 = nv % 256; m_c1 = nv / 256;
        end
      end else begin
        if (tk0 != 0) begin
          if (m_c0 == 0) begin u0 = 1; m_c0 = m_d0; end else m_c0 = m_c0 - 1;
        end
        if (tk1 != 0) begin
          if (m_c1 == 0) begin u1 = 1; m_c1 = m_d1; end else m_c1 = m_c1 - 1;
        end
      end
      m_st = m_st | ((u1 * 2 + u0) & m_en);
      if (m_ini != 0) begin m_p28 = 0; m_p114 = 0; end
      else begin m_p28 = (m_p28 + 1) % 28; m_p114 = (m_p114 + 1) % 114; end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_d0 = wr_data;
          3'd1: m_k0 = wr_data;
          3'd2: m_d1 = wr_data;
          3'd3: m_k1 = wr_data;
          3'd4: m_md = wr_data;
          3'd6: begin
            if (wr_data[1:0] == 2'b00) m_ini = 1;
            else if (wr_data[1:0] == 2'b11) m_ini = 0;
          end
          3'd7: begin m_en = wr_data & 3; m_st = m_st & m_en; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    int a0, a1;
    if (rst_n) begin
      a0 = (m_k0 & 16) ? (m_k0 & 15) : 0;
      a1 = (m_k1 & 16) ? (m_k1 & 15) : 0;
      chk(irq == (m_st != 0), "R6 model irq", int'(irq), int'(m_st != 0));
      chk(aud == 8'(a1 * 16 + a0), "R9 model aud", int'(aud), a1 * 16 + a0);
    end
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_irq(input int lim, input string tag);
    int n = 0;
    while (!irq && n < lim) begin
      @(negedge clk);
      n++;
    end
    chk(irq == 1'b1, tag, int'(irq), 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int s, a, b, rel;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
    chk(aud == 8'h00, "R1 aud after reset", int'(aud), 0);

    // R9 volume-only levels
    wr(3'd1, 8'h1A);
    chk(aud[3:0] == 4'hA, "R9 ch0 volume-only", int'(aud[3:0]), 10);
    wr(3'd1, 8'h0A);
    chk(aud[3:0] == 4'h0, "R9 ch0 not volume-only", int'(aud[3:0]), 0);
    wr(3'd3, 8'h15);
    chk(aud[7:4] == 4'h5, "R9 ch1 volume-only", int'(aud[7:4]), 5);

    // R6 disabled channels never raise irq
    wr(3'd7, 8'h00);
    wr(3'd4, 8'h02);
    wr(3'd0, 8'h02);
    wr(3'd5, 8'h00);
    idle(20);
    chk(irq == 1'b0, "R6 underflow with enable low", int'(irq), 0);
    wr(3'd7, 8'h02);
    idle(20);
    chk(irq == 1'b0, "R6 other channel enable only", int'(irq), 0);

    // R3 fast period
    wr(3'd7, 8'h00);
    wr(3'd0, 8'h05);
    wr(3'd5, 8'h00); s = cyc;
    wr(3'd7, 8'h01);
    wait_irq(50, "R3 fast underflow seen");
    chk(cyc - s == 6, "R3 fast first underflow", cyc - s, 6);

    // R7 level hold and clear
    idle(20);
    chk(irq == 1'b1, "R7 irq held", int'(irq), 1);
    wr(3'd7, 8'h00);
    chk(irq == 1'b0, "R7 irq cleared on write", int'(irq), 0);

    // R10 periodic reload
    wr(3'd0, 8'h09);
    wr(3'd5, 8'h00);
    wr(3'd7, 8'h01);
    wait_irq(50, "R10 first rise"); a = cyc;
    wr(3'd7, 8'h00); wr(3'd7, 8'h01);
    wait_irq(50, "R10 second rise"); b = cyc;
    chk(b - a == 10, "R10 reload period", b - a, 10);

    // R5 and R4: prescaler phase set by leaving init, not by start
    wr(3'd7, 8'h00);
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h00);
    wr(3'd7, 8'h01);
    idle(5);
    chk(irq == 1'b0, "R5 no slow tick while init held", int'(irq), 0);
    wr(3'd6, 8'h03); rel = cyc;
    idle(10);
    wr(3'd5, 8'h00);
    wait_irq(100, "R4 slow underflow seen");
    chk(cyc - rel == 28, "R4 R5 first tick from release", cyc - rel, 28);

    // R2 mid-rate period
    wr(3'd0, 8'h01);
    wr(3'd7, 8'h00); wr(3'd7, 8'h01);
    wait_irq(200, "R2 mid rise a"); a = cyc;
    wr(3'd7, 8'h00); wr(3'd7, 8'h01);
    wait_irq(200, "R2 mid rise b"); b = cyc;
    chk(b - a == 56, "R2 divide-by-28 period", b - a, 56);

    // R2 line-rate period
    wr(3'd4, 8'h01);
    wr(3'd7, 8'h00); wr(3'd7, 8'h01);
    wait_irq(600, "R2 line rise a"); a = cyc;
    wr(3'd7, 8'h00); wr(3'd7, 8'h01);
    wait_irq(600, "R2 line rise b"); b = cyc;
    chk(b - a == 228, "R2 divide-by-114 period", b - a, 228);

    // R5 init holds prescalers
    wr(3'd6, 8'h00);
    wr(3'd7, 8'h00); wr(3'd7, 8'h01);
    idle(300);
    chk(irq == 1'b0, "R5 init state stops slow ticks", int'(irq), 0);

    // R8 joined 16-bit counter
    wr(3'd4, 8'h0A);
    wr(3'd0, 8'h02);
    wr(3'd2, 8'h01);
    wr(3'd7, 8'h00);
    wr(3'd5, 8'h00); s = cyc;
    wr(3'd7, 8'h03);
    while (cyc < s + 100) @(negedge clk);
    chk(irq == 1'b0, "R8 low byte alone gives no irq", int'(irq), 0);
    wait_irq(400, "R8 joined underflow seen");
    chk(cyc - s == 259, "R8 joined period", cyc - s, 259);

    idle(5);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule